// File: doc/BRIEF.md
# SPI NOR Flash Operation Sequencer

This block is the master side of a serial NOR flash link. It runs one complete flash operation for each request: a byte read of any length, a 256-byte page program, a 4 KiB sector erase, or an erase of the whole chip. The requester gives the operation code, a 24-bit byte address and, for reads, a byte count. Program data arrives on a valid/ready input stream. Read data leaves on a valid/ready output stream. When the operation is finished the block pulses `op_done` and shows the error result on `op_err`.

Every operation begins by polling the device. The block sends a status-read frame and keeps sending it, with a programmable idle gap between attempts, until the busy bit reads clear. A program or erase then gets a write-enable frame of its own. After that the block sends the command frame: the opcode, then the address with its most significant byte first, then any data. Chip select goes high between any two frames and stays high for at least one full SCLK period. The serial clock runs in SPI mode 0 at `clk / (2*CLK_HALF)`.

The controller is a single state machine with these states:
- IDLE: waits for a request.
- POLL_CMD, POLL_DUMMY: the two bytes of a status frame.
- GAP: chip select high.
- WREN: the write-enable frame.
- OPCODE and ADDR: the command and its address.
- WDATA: program bytes.
- RDATA and RHOLD: shifting a read byte, then offering it.
- DONE: completion.

Its transitions are:
- IDLE→POLL_CMD when a request is accepted.
- POLL_CMD→POLL_DUMMY.
- POLL_DUMMY→GAP. The gap returns to POLL_CMD if the device is busy. If it is idle, the gap goes on to WREN for program and erase, or to OPCODE for a read.
- WREN→GAP→OPCODE.
- OPCODE→ADDR, or OPCODE→GAP→DONE for a chip erase.
- ADDR→RDATA, ADDR→WDATA, or ADDR→GAP→DONE.
- WDATA→GAP→DONE after 256 bytes.
- RDATA→RHOLD. RHOLD→RDATA while bytes remain, otherwise RHOLD→GAP→DONE.
- DONE→IDLE.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `spi_cs_n`=1, `spi_sclk`=0, `req_ready`=1, `rd_valid`=0 and `op_done`=0.
- R2: Bytes use SPI mode 0. SCLK idles low and is low whenever chip select is high. MOSI is sampled on the rising edge, most significant bit first. Every byte is exactly 8 SCLK pulses.
- R3: Every operation starts with a status frame: byte 0x05, then filler byte 0xA5, with the status returned during the filler. The frame repeats while status bit 0 (busy) is 1. The operation goes on only after a status with bit 0 = 0.
- R4: Between two consecutive status frames, chip select stays high for at least `poll_gap` clock cycles, and for no more than `poll_gap`+3 cycles.
- R5: A program or erase is preceded by a one-byte frame 0x06 in its own chip-select frame, placed after the last status frame. A read has no such frame.
- R6: Read (`req_op`=0) sends 0x03 and the three address bytes, most significant first. It then sends `req_len` filler bytes 0xA5 and returns the byte received during each one. With `req_len`=0 the frame is the 4 header bytes only.
- R7: `rd_valid` stays asserted with `rd_data` stable until `rd_ready` accepts the byte.
- R8: Page program (`req_op`=1) sends 0x02, then the address with bits 7:0 forced to zero, then exactly 256 bytes taken in order from the `wr_data` stream.
- R9: Sector erase (`req_op`=2) sends 0x20, then the address with bits 11:0 forced to zero, and no data.
- R10: Chip erase (`req_op`=3) is a one-byte frame 0xC7 with no address.
- R11: `op_err` is 1 at `op_done` exactly when status bit 5 was set in the poll that found the device idle. Bit 5 seen during a busy poll does not count.
- R12: Chip select is high for at least 2*`CLK_HALF` clock cycles between any two frames.
- R13: `op_done` is a one-cycle pulse, and `req_ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| poll_gap | input | GAP_W | Idle clock cycles between busy polls |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 2 | 0 read, 1 page program, 2 sector erase, 3 chip erase |
| req_addr | input | 24 | Byte address |
| req_len | input | LEN_W | Read byte count |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Program byte taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte accepted |
| op_done | output | 1 | Operation finished pulse |
| op_err | output | 1 | Error result of the operation |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The hardest case to reach from the ports is the busy-poll loop. It only runs when the device model reports busy across several status frames. A second hard case is the error bit, which must be judged only on the poll that ends the loop. The bench's flash model therefore holds a count of busy answers and a separate error setting. It can return bit 5 together with the busy bit, or alone on the idle answer. It timestamps every chip-select edge, so the gap before each frame can be compared with `poll_gap`. Read and program streams are throttled from the bench, which forces the hold state and stalls in the middle of a page.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_CMD,
        ST_POLL_DUMMY,
        ST_GAP,
        ST_WREN,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_RHOLD,
        ST_DONE
    } st_e;

    localparam logic [7:0] BYTE_STATUS = 8'h05;
    localparam logic [7:0] BYTE_WEN    = 8'h06;
    localparam logic [7:0] BYTE_READ   = 8'h03;
    localparam logic [7:0] BYTE_PROG   = 8'h02;
    localparam logic [7:0] BYTE_SECT   = 8'h20;
    localparam logic [7:0] BYTE_CHIP   = 8'hC7;
    localparam logic [7:0] BYTE_FILL   = 8'hA5;

    localparam int BUSY_BIT = 0;
    localparam int FAIL_BIT = 5;
    localparam int ADDR_W   = 24;

endpackage

// File: rtl/nor_spi_shifter.sv
module nor_spi_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);

    logic [DIV_W-1:0] div_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;
    logic [7:0]       rx_q;
    logic             busy_q;
    logic             sclk_q;
    logic             done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    sh_q   <= tx_byte;
                    busy_q <= 1'b1;
                    div_q  <= '0;
                    bit_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (div_q == DIV_W'(HALF_DIV - 1)) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_byte = rx_q;
    assign sclk    = sclk_q;
    assign mosi    = sh_q[7];

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);                                              // R2
    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);                                            // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);                                             // R2

endmodule

// File: rtl/nor_gap_timer.sv
module nor_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));                              // R4

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int CLK_HALF   = 2,
    parameter int GAP_W      = 16,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GAP_W-1:0] poll_gap,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             op_done,
    output logic             op_err,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);
    localparam int PAGE_W  = $clog2(PAGE_BYTES);
    localparam int CNT_W   = (LEN_W > PAGE_W + 1) ? LEN_W : PAGE_W + 1;
    localparam int MIN_GAP = 2 * CLK_HALF;
    localparam int CHK_W   = $clog2(MIN_GAP + 2) + 1;

    st_e              state_q, state_d;
    st_e              gap_next_q, gap_next_d;
    op_e              op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       aidx_q;
    logic             err_q;
    logic [7:0]       rdata_q;

    logic             sh_start, sh_busy, sh_done;
    logic [7:0]       sh_tx, sh_rx;
    logic             gap_load, gap_expired;
    logic [GAP_W-1:0] gap_val;
    logic [GAP_W-1:0] poll_eff;
    logic             byte_state, launch;
    logic             last_rd, last_wr;
    logic [7:0]       opcode;

    nor_spi_shifter #(.HALF_DIV(CLK_HALF)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    nor_gap_timer #(.W(GAP_W)) gap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_expired)
    );

    assign poll_eff = (poll_gap < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : poll_gap;
    assign last_rd  = (cnt_q == CNT_W'(len_q - LEN_W'(1)));
    assign last_wr  = (cnt_q == CNT_W'(PAGE_BYTES - 1));

    always_comb begin
        unique case (op_q)
            OP_READ: opcode = BYTE_READ;
            OP_PROG: opcode = BYTE_PROG;
            OP_SECT: opcode = BYTE_SECT;
            OP_CHIP: opcode = BYTE_CHIP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            gap_next_q <= ST_IDLE;
        end else begin
            state_q    <= state_d;
            gap_next_q <= gap_next_d;
        end
    end

    // next state and gap control
    always_comb begin
        state_d    = state_q;
        gap_next_d = gap_next_q;
        gap_load   = 1'b0;
        gap_val    = GAP_W'(MIN_GAP);
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_POLL_CMD;
            end
            ST_POLL_CMD: begin
                if (sh_done) state_d = ST_POLL_DUMMY;
            end
            ST_POLL_DUMMY: begin
                if (sh_done) begin
                    state_d  = ST_GAP;
                    gap_load = 1'b1;
                    if (sh_rx[BUSY_BIT]) begin
                        gap_val    = poll_eff;
                        gap_next_d = ST_POLL_CMD;
                    end else begin
                        gap_next_d = (op_q == OP_READ) ? ST_OPCODE : ST_WREN;
                    end
                end
            end
            ST_GAP: begin
                if (gap_expired) state_d = gap_next_q;
            end
            ST_WREN: begin
                if (sh_done) begin
                    state_d    = ST_GAP;
                    gap_load   = 1'b1;
                    gap_next_d = ST_OPCODE;
                end
            end
            ST_OPCODE: begin
                if (sh_done) begin
                    if (op_q == OP_CHIP) begin
                        state_d    = ST_GAP;
                        gap_load   = 1'b1;
                        gap_next_d = ST_DONE;
                    end else begin
                        state_d = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                if (sh_done && aidx_q == 2'd2) begin
                    if (op_q == OP_PROG) begin
                        state_d = ST_WDATA;
                    end else if (op_q == OP_READ && len_q != '0) begin
                        state_d = ST_RDATA;
                    end else begin
                        state_d    = ST_GAP;
                        gap_load   = 1'b1;
                        gap_next_d = ST_DONE;
                    end
                end
            end
            ST_WDATA: begin
                if (sh_done && last_wr) begin
                    state_d    = ST_GAP;
                    gap_load   = 1'b1;
                    gap_next_d = ST_DONE;
                end
            end
            ST_RDATA: begin
                if (sh_done) state_d = ST_RHOLD;
            end
            ST_RHOLD: begin
                if (rd_ready) begin
                    if (last_rd) begin
                        state_d    = ST_GAP;
                        gap_load   = 1'b1;
                        gap_next_d = ST_DONE;
                    end else begin
                        state_d = ST_RDATA;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and byte launch
    always_comb begin
        byte_state = 1'b0;
        sh_tx      = BYTE_FILL;
        unique case (state_q)
            ST_POLL_CMD:   begin byte_state = 1'b1; sh_tx = BYTE_STATUS; end
            ST_POLL_DUMMY: begin byte_state = 1'b1; sh_tx = BYTE_FILL;   end
            ST_WREN:       begin byte_state = 1'b1; sh_tx = BYTE_WEN;    end
            ST_OPCODE:     begin byte_state = 1'b1; sh_tx = opcode;      end
            ST_ADDR:       begin byte_state = 1'b1; sh_tx = addr_q[8*(2-aidx_q) +: 8]; end
            ST_WDATA:      begin byte_state = 1'b1; sh_tx = wr_data;     end
            ST_RDATA:      begin byte_state = 1'b1; sh_tx = BYTE_FILL;   end
            default:       begin byte_state = 1'b0; sh_tx = BYTE_FILL;   end
        endcase
        launch    = byte_state && !sh_busy && !sh_done;
        wr_ready  = launch && (state_q == ST_WDATA);
        sh_start  = launch && ((state_q != ST_WDATA) || wr_valid);
        spi_cs_n  = !(byte_state || state_q == ST_RHOLD);
        req_ready = (state_q == ST_IDLE);
        rd_valid  = (state_q == ST_RHOLD);
        op_done   = (state_q == ST_DONE);
    end

    assign rd_data = rdata_q;
    assign op_err  = err_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            addr_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            aidx_q  <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q   <= op_e'(req_op);
                len_q  <= req_len;
                cnt_q  <= '0;
                aidx_q <= '0;
                err_q  <= 1'b0;
                unique case (op_e'(req_op))
                    OP_PROG: addr_q <= {req_addr[23:8], 8'h00};
                    OP_SECT: addr_q <= {req_addr[23:12], 12'h000};
                    default: addr_q <= req_addr;
                endcase
            end
            if (state_q == ST_POLL_DUMMY && sh_done && !sh_rx[BUSY_BIT])
                err_q <= sh_rx[FAIL_BIT];
            if (state_q == ST_ADDR && sh_done)
                aidx_q <= aidx_q + 2'd1;
            if (state_q == ST_WDATA && sh_done)
                cnt_q <= cnt_q + CNT_W'(1);
            if (state_q == ST_RDATA && sh_done)
                rdata_q <= sh_rx;
            if (state_q == ST_RHOLD && rd_ready)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // chip-select high time, kept for the gap check
    logic [CHK_W-1:0] cs_hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cs_hi_cnt <= '1;
        else if (!spi_cs_n)       cs_hi_cnt <= '0;
        else if (cs_hi_cnt != '1) cs_hi_cnt <= cs_hi_cnt + CHK_W'(1);
    end

    AST_CS_HIGH_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);                                         // R2
    AST_CS_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> cs_hi_cnt >= CHK_W'(MIN_GAP));               // R12
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));     // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (!op_done && req_ready));                            // R13
    AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n);                                         // R8

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;
    localparam int CLK_HALF = 2;
    localparam int MIN_GAP  = 2 * CLK_HALF;
    localparam int PER      = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] poll_gap = 16'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [7:0]  wr_data;
    logic        wr_valid;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready;
    logic        op_done, op_err;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    always #(PER/2) clk = ~clk;

    nor_cmd_seq #(.CLK_HALF(CLK_HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .poll_gap(poll_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .op_done(op_done), .op_err(op_err),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] wpat(input int i);
        return 8'(i * 3 + 17);
    endfunction
    function automatic logic [7:0] rpat(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    // program data feed with stalls
    logic wr_en = 1'b0;
    int   wr_idx = 0;
    assign wr_valid = wr_en && (cyc % 4 != 1);
    assign wr_data  = wpat(wr_idx);
    always @(posedge clk) if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;

    // read data sink with throttle
    logic       rd_thr = 1'b0;
    logic [7:0] rd_buf [0:63];
    int         rd_n = 0;
    int         hold_err = 0;
    logic       prev_hold = 1'b0;
    logic [7:0] prev_data = '0;
    assign rd_ready = !rd_thr || (cyc % 3 == 0);
    always @(posedge clk) if (rd_valid && rd_ready) begin
        rd_buf[rd_n % 64] <= rd_data;
        rd_n <= rd_n + 1;
    end
    always @(negedge clk) begin
        if (prev_hold && (!rd_valid || rd_data != prev_data)) hold_err++;
        prev_hold = rd_valid && !rd_ready;
        prev_data = rd_data;
    end

    // flash device model
    int         fr_cnt = 0;
    logic [7:0] fr_op   [0:63];
    int         fr_n    [0:63];
    logic [23:0] fr_addr[0:63];
    int         fr_mis  [0:63];
    int         fr_rem  [0:63];
    int         fr_gap  [0:63];
    int         busy_left = 0;
    logic       busy_err = 1'b0;
    logic       idle_err = 1'b0;
    int         nb = 0, bc = 0, cur = 0;
    int         stray_clk = 0;
    logic [7:0] sh = '0, resp = '0, cop = '0;
    time        t_rise = 0;

    always @(negedge spi_cs_n) begin
        cur = fr_cnt % 64;
        nb = 0; bc = 0; resp = '0; spi_miso = 1'b0;
        fr_op[cur] = '0; fr_addr[cur] = '0; fr_mis[cur] = 0;
        fr_gap[cur] = int'(($time - t_rise) / PER);
    end
    always @(posedge spi_cs_n) begin
        fr_n[cur] = nb;
        fr_rem[cur] = bc;
        fr_cnt++;
        t_rise = $time;
    end
    always @(posedge spi_sclk) begin
        if (spi_cs_n) stray_clk++;
        else begin
            sh = {sh[6:0], spi_mosi};
            bc++;
            if (bc == 8) begin
                bc = 0;
                if (nb == 0) begin
                    cop = sh; fr_op[cur] = sh;
                end else if (nb <= 3) begin
                    fr_addr[cur] = {fr_addr[cur][15:0], sh};
                end
                if (cop == 8'h05 && nb >= 1 && sh != 8'hA5) fr_mis[cur]++;
                if (cop == 8'h03 && nb >= 4 && sh != 8'hA5) fr_mis[cur]++;
                if (cop == 8'h02 && nb >= 4 && sh != wpat(nb - 4)) fr_mis[cur]++;
                nb++;
                resp = '0;
                if (cop == 8'h05 && nb == 1) begin
                    if (busy_left > 0) begin
                        busy_left--;
                        resp = busy_err ? 8'h21 : 8'h01;
                    end else begin
                        resp = idle_err ? 8'h20 : 8'h00;
                    end
                end else if (cop == 8'h03 && nb >= 4) begin
                    resp = rpat(8'(fr_addr[cur][7:0] + 8'(nb - 4)));
                end
            end
        end
    end
    always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = resp[7 - bc];

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    logic got_err;
    task automatic run_op(input logic [1:0] op, input logic [23:0] a, input logic [15:0] len);
        int t;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!op_done && t < 40000) begin @(negedge clk); t++; end
        check(op_done, "R13 op_done seen", int'(op_done), 1);
        got_err = op_err;
        @(negedge clk);
        check(!op_done && req_ready, "R13 one-cycle done, ready after",
              int'({op_done, req_ready}), 1);
    endtask

    task automatic t_reset();
        check(spi_cs_n && !spi_sclk && req_ready && !rd_valid && !op_done,
              "R1 reset outputs",
              int'({spi_cs_n, spi_sclk, req_ready, rd_valid, op_done}), 5'b10100);
    endtask

    task automatic t_read();
        int b = fr_cnt; int r0 = rd_n;
        rd_thr = 1'b1;
        run_op(2'd0, 24'h12A5F0, 16'd6);
        rd_thr = 1'b0;
        check(fr_cnt - b == 2, "R5 read has two frames", fr_cnt - b, 2);
        check(fr_op[b] == 8'h05 && fr_n[b] == 2 && fr_mis[b] == 0, "R3 status frame",
              int'(fr_op[b]), 8'h05);
        check(fr_op[b+1] == 8'h03 && fr_n[b+1] == 10, "R6 read frame op/len",
              fr_n[b+1], 10);
        check(fr_addr[b+1] == 24'h12A5F0, "R6 read address", int'(fr_addr[b+1]), 24'h12A5F0);
        check(fr_mis[b+1] == 0, "R6 filler bytes 0xA5", fr_mis[b+1], 0);
        check(rd_n - r0 == 6, "R6 byte count", rd_n - r0, 6);
        for (int i = 0; i < 6; i++)
            check(rd_buf[(r0 + i) % 64] == rpat(8'(8'hF0 + i)), "R6 read data",
                  int'(rd_buf[(r0 + i) % 64]), int'(rpat(8'(8'hF0 + i))));
        check(hold_err == 0, "R7 rd_valid/rd_data held", hold_err, 0);
        check(fr_rem[b] == 0 && fr_rem[b+1] == 0 && stray_clk == 0,
              "R2 whole bytes, no clock outside frame", fr_rem[b+1] + stray_clk, 0);
        check(fr_gap[b+1] >= MIN_GAP, "R12 gap before read frame", fr_gap[b+1], MIN_GAP);
        check(!got_err, "R11 no error", int'(got_err), 0);
    endtask

    task automatic t_read_zero();
        int b = fr_cnt; int r0 = rd_n;
        run_op(2'd0, 24'h000102, 16'd0);
        check(fr_op[b+1] == 8'h03 && fr_n[b+1] == 4, "R6 zero-length read", fr_n[b+1], 4);
        check(rd_n == r0, "R6 zero-length no data", rd_n - r0, 0);
    endtask

    task automatic t_program();
        int b = fr_cnt;
        wr_en = 1'b1;
        run_op(2'd1, 24'h0345AB, 16'd0);
        wr_en = 1'b0;
        check(fr_cnt - b == 3, "R5 program frames", fr_cnt - b, 3);
        check(fr_op[b+1] == 8'h06 && fr_n[b+1] == 1, "R5 write enable frame",
              int'(fr_op[b+1]), 8'h06);
        check(fr_gap[b+1] >= MIN_GAP && fr_gap[b+2] >= MIN_GAP, "R12 gaps around wren",
              fr_gap[b+2], MIN_GAP);
        check(fr_op[b+2] == 8'h02 && fr_n[b+2] == 260, "R8 program length", fr_n[b+2], 260);
        check(fr_addr[b+2] == 24'h034500, "R8 page address", int'(fr_addr[b+2]), 24'h034500);
        check(fr_mis[b+2] == 0, "R8 program data order", fr_mis[b+2], 0);
        check(wr_idx == 256, "R8 bytes taken from stream", wr_idx, 256);
    endtask

    task automatic t_sector();
        int b = fr_cnt;
        run_op(2'd2, 24'h0ABCDE, 16'd0);
        check(fr_op[b+1] == 8'h06, "R5 sector wren", int'(fr_op[b+1]), 8'h06);
        check(fr_op[b+2] == 8'h20 && fr_n[b+2] == 4, "R9 sector frame", fr_n[b+2], 4);
        check(fr_addr[b+2] == 24'h0AB000, "R9 sector address", int'(fr_addr[b+2]), 24'h0AB000);
    endtask

    task automatic t_chip();
        int b = fr_cnt;
        run_op(2'd3, 24'hFFFFFF, 16'd0);
        check(fr_cnt - b == 3 && fr_op[b+1] == 8'h06, "R5 chip wren", fr_cnt - b, 3);
        check(fr_op[b+2] == 8'hC7 && fr_n[b+2] == 1, "R10 chip erase frame", fr_n[b+2], 1);
    endtask

    task automatic t_poll();
        int b = fr_cnt;
        poll_gap = 16'd40;
        busy_left = 3;
        run_op(2'd0, 24'h000010, 16'd1);
        check(fr_cnt - b == 5, "R3 four polls then read", fr_cnt - b, 5);
        for (int i = 0; i < 4; i++)
            check(fr_op[b+i] == 8'h05 && fr_n[b+i] == 2, "R3 poll frame", int'(fr_op[b+i]), 5);
        for (int i = 1; i < 4; i++)
            check(fr_gap[b+i] >= 40 && fr_gap[b+i] <= 43, "R4 poll gap", fr_gap[b+i], 40);
        check(fr_op[b+4] == 8'h03, "R3 proceeds after idle", int'(fr_op[b+4]), 3);
        poll_gap = 16'd0;
    endtask

    task automatic t_err();
        idle_err = 1'b1;
        run_op(2'd3, 24'h0, 16'd0);
        check(got_err, "R11 error at idle poll", int'(got_err), 1);
        idle_err = 1'b0;
        busy_err = 1'b1;
        busy_left = 1;
        run_op(2'd2, 24'h001000, 16'd0);
        check(!got_err, "R11 error bit while busy ignored", int'(got_err), 0);
        busy_err = 1'b0;
    endtask

    initial begin
        #(PER * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_read();
        t_read_zero();
        t_program();
        t_sector();
        t_chip();
        t_poll();
        t_err();
        finish_run();
    end

endmodule